// File: doc/BRIEF.md
# Checksummed Memory Transaction Cell Processor

This block sits on a word-serial cell path and serves memory access requests carried inside control cells. A request names a bank, an access width, a read or write direction, a starting address and a count of consecutive accesses. The block performs those accesses in address order on a simple synchronous memory port. It then returns a response cell that echoes the data written or the data read at each location.

Every cell carries a 16-bit ones-complement checksum. A corrupted request is dropped without any access and without any output, so the remote software's stop-and-wait timer fires and the request is sent again. The operations are idempotent: a repeated write stores the same values, and a repeated read returns the same values. The block can therefore accept a resent request without harm. Cells meant for another module, and response cells travelling downstream, leave the block unchanged.

A cell is `CELL_LEN` (20) words of 32 bits. Word 0 is the header and word 1 holds the start address. Words 2 to 17 form a 16-word data area, word 18 is spare and word 19 carries the checksum. Header bits: [31:24] destination module number, [23] response flag, [22:21] width code (0 = 32-bit, 1 = 36-bit, 2 = 64-bit, 3 = invalid), [20] write (1) or read (0), [19] bank, [18:15] access count, [14:8] spare, [7:0] status (0 = done, 1 = rejected).

Top module: `cellmem_proc`

## Requirements
- R1: An input cell starts with a word marked by `in_sop` and is exactly `CELL_LEN` words long. An output cell appears on `out_valid` as `CELL_LEN` words on consecutive cycles, and its first word is marked by `out_sop`.
- R2: A cell addressed to this block is valid only if the 16-bit ones-complement sum of all 40 halfwords of its 20 words equals 0xFFFF. A cell that fails this check causes no memory access and no output cell, and `in_ready` returns high.
- R3: A cell whose header bits [31:24] differ from `MODULE_ID`, or whose response flag bit 23 is set, is emitted word for word unchanged, including its checksum word. It causes no memory access.
- R4: A valid request performs `count` accesses, one per cycle. They run in ascending address order starting at the address in word 1 (low `ADDR_W` bits) and use the bank in header bit 19.
- R5: In 32-bit width, datum k sits in word 2+k. In 36-bit and 64-bit widths, datum k takes word 2+2k for bits 31:0 and word 3+2k for the upper bits. The 36-bit width uses only bits 3:0 of the upper word.
- R6: A read returns, in the response, the memory data in the same word layout as R5. The memory port delivers read data one cycle after the request.
- R7: The count must lie between 1 and 8 for width 0, between 1 and 6 for width 1, and between 1 and 4 for width 2. Width code 3, or a count outside these ranges, causes no access. Such a request gets a response with status 1 and its data words unchanged.
- R8: A response has word 0 equal to the request header with bit 23 set and status [7:0] set to 0 on success. Word 1, word 18 and every data word not used by an access are copied from the request. Word 19 holds zero in bits 31:16 and, in bits 15:0, the ones-complement of the ones-complement sum of the halfwords of words 0 to 18.
- R9: For a write, the response data words carry the value stored in memory. A 36-bit write stores and echoes only bits 35:0, so bits 31:4 of each upper word read back as zero.
- R10: No response word is emitted while a memory access of the same cell is in progress. The response begins only after the last access has completed.
- R11: Sending the same request twice produces two identical response cells and leaves memory identical.
- R12: `in_ready` is high after reset. It goes low from the last word of an accepted cell until that cell's output has been sent or the cell has been dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Marks first word of an input cell |
| in_data | input | 32 | Input cell word |
| in_ready | output | 1 | Block can take input words |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Marks first word of an output cell |
| out_data | output | 32 | Output cell word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_bank | output | 1 | Bank select |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read request |

## Verification
The properties assume that the sender starts a new cell only while `in_ready` is high. They also assume that the memory answers each read exactly one cycle later. The bench waits for `in_ready` before it drives each cell, and its memory model registers read data on the edge that samples the request. The address-step and count properties rely on a cell holding only one access direction and one width, which the header encoding enforces. Each scenario sends complete cells and never drives words between cells.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [1:0] WID_32 = 2'd0;
  localparam logic [1:0] WID_36 = 2'd1;
  localparam logic [1:0] WID_64 = 2'd2;

  typedef struct packed {
    logic [7:0] mod_id;
    logic       rsp;
    logic [1:0] width;
    logic       wr;
    logic       bank;
    logic [3:0] count;
    logic [6:0] spare;
    logic [7:0] status;
  } hdr_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} sq_st_e;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] oc_word(input logic [15:0] acc, input logic [31:0] w);
    return oc_add(oc_add(acc, w[15:0]), w[31:16]);
  endfunction
endpackage

// File: rtl/ccp_rx.sv
module ccp_rx
  import ccp_pkg::*;
#(
  parameter int CELL_LEN = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [31:0] in_data,
  input  logic        release_i,
  output logic        in_ready,
  output logic [31:0] cell_buf [CELL_LEN],
  output logic        cell_done,
  output logic        cell_ok
);
  localparam int IDX_W = $clog2(CELL_LEN);

  logic             hold, in_cell, accept;
  logic [IDX_W-1:0] cnt, wr_idx;
  logic [15:0]      acc, acc_nxt;

  assign accept   = in_valid && !hold && (in_sop || in_cell);
  assign wr_idx   = in_sop ? '0 : cnt;
  assign acc_nxt  = oc_word(in_sop ? 16'h0000 : acc, in_data);
  assign in_ready = !hold;

  always_ff @(posedge clk) begin
    if (accept) cell_buf[wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= 1'b0;
      in_cell   <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      cell_done <= 1'b0;
      cell_ok   <= 1'b0;
    end else begin
      cell_done <= 1'b0;
      if (release_i) hold <= 1'b0;
      if (accept) begin
        if (wr_idx == IDX_W'(CELL_LEN - 1)) begin
          hold      <= 1'b1;
          cell_done <= 1'b1;
          cell_ok   <= (acc_nxt == 16'hFFFF);
          in_cell   <= 1'b0;
          cnt       <= '0;
        end else begin
          in_cell <= 1'b1;
          cnt     <= wr_idx + 1'b1;
          acc     <= acc_nxt;
        end
      end
    end
  end

  // R12: a held cell is never overwritten
  a_r12_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cell_buf[0]));
endmodule

// File: rtl/ccp_seq.sv
module ccp_seq
  import ccp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 16,
  parameter int LIM32  = 8,
  parameter int LIM36  = 6,
  parameter int LIM64  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  hdr_t              hdr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       slot_in [SLOTS],
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic [31:0]       echo_slot [SLOTS],
  output logic [SLOTS-1:0]  echo_vld,
  output logic              err,
  output logic              done
);
  localparam int SLOT_W = $clog2(SLOTS);

  sq_st_e            st;
  logic [3:0]        k, cnt_r, rd_k, put_k;
  logic [1:0]        wid_r;
  logic              wr_r, bank_r, rd_pend, put_en, hdr_ok;
  logic [ADDR_W-1:0] base_r;
  logic [SLOT_W-1:0] lo_idx, hi_idx, put_lo;
  logic [31:0]       lo_w, hi_w;
  logic [63:0]       put_d;

  function automatic logic [3:0] lim(input logic [1:0] w);
    case (w)
      WID_32:  return 4'(LIM32);
      WID_36:  return 4'(LIM36);
      WID_64:  return 4'(LIM64);
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] first_slot(input logic [1:0] w, input logic [3:0] n);
    return (w == WID_32) ? SLOT_W'(n) : SLOT_W'({n, 1'b0});
  endfunction

  assign hdr_ok = (hdr_i.count != 4'd0) && (hdr_i.count <= lim(hdr_i.width));

  // request side: driven from state registers only
  assign lo_idx   = first_slot(wid_r, k);
  assign hi_idx   = lo_idx + 1'b1;
  assign lo_w     = slot_in[lo_idx];
  assign hi_w     = slot_in[hi_idx];
  assign mem_req  = (st == SQ_RUN);
  assign mem_we   = wr_r;
  assign mem_bank = bank_r;
  assign mem_addr = base_r + ADDR_W'(k);
  always_comb begin
    case (wid_r)
      WID_32:  mem_wdata = {32'h0, lo_w};
      WID_36:  mem_wdata = {28'h0, hi_w[3:0], lo_w};
      default: mem_wdata = {hi_w, lo_w};
    endcase
  end

  assign done = (st == SQ_FIN) && !rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      k       <= '0;
      cnt_r   <= '0;
      rd_k    <= '0;
      wid_r   <= WID_32;
      wr_r    <= 1'b0;
      bank_r  <= 1'b0;
      base_r  <= '0;
      rd_pend <= 1'b0;
      err     <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          wid_r  <= hdr_i.width;
          wr_r   <= hdr_i.wr;
          bank_r <= hdr_i.bank;
          cnt_r  <= hdr_i.count;
          base_r <= base_i;
          k      <= '0;
          err    <= !hdr_ok;
          st     <= hdr_ok ? SQ_RUN : SQ_FIN;
        end
        SQ_RUN: begin
          if (!wr_r) begin
            rd_pend <= 1'b1;
            rd_k    <= k;
          end
          k <= k + 1'b1;
          if (k == cnt_r - 1'b1) st <= SQ_FIN;
        end
        SQ_FIN: if (!rd_pend) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // echo capture: written data at issue, read data one cycle later
  assign put_en = (mem_req && wr_r) || rd_pend;
  assign put_k  = rd_pend ? rd_k : k;
  assign put_d  = rd_pend ? mem_rdata : mem_wdata;
  assign put_lo = first_slot(wid_r, put_k);

  always_ff @(posedge clk) begin
    if (put_en) begin
      echo_slot[put_lo] <= put_d[31:0];
      if (wid_r != WID_32)
        echo_slot[put_lo + 1'b1] <= (wid_r == WID_36) ? {28'h0, put_d[35:32]} : put_d[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) echo_vld <= '0;
    else if (put_en) begin
      echo_vld[put_lo] <= 1'b1;
      if (wid_r != WID_32) echo_vld[put_lo + 1'b1] <= 1'b1;
    end
  end

  // R7: never more accesses than the width allows
  a_r7_count_within_limit: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (k < lim(wid_r)));
  // R5: accessed data words stay inside the data area
  a_r5_slots_fit: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (32'(k) * ((wid_r == WID_32) ? 1 : 2) < SLOTS));
  // R4: back-to-back accesses step the address by one on a fixed bank
  a_r4_addr_ascends: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 1'b1 && $stable(mem_bank)));
  // R6: read data is captured only the cycle after a read request
  a_r6_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_pend |-> $past(mem_req && !mem_we));
endmodule

// File: rtl/ccp_tx.sv
module ccp_tx
  import ccp_pkg::*;
#(
  parameter int CELL_LEN = 20,
  parameter int SLOTS    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pass,
  input  logic             start_rsp,
  input  logic [31:0]      cell_buf [CELL_LEN],
  input  logic [31:0]      echo_slot [SLOTS],
  input  logic [SLOTS-1:0] echo_vld,
  input  logic [7:0]       status,
  output logic             out_valid,
  output logic             out_sop,
  output logic [31:0]      out_data,
  output logic             done
);
  localparam int IDX_W  = $clog2(CELL_LEN);
  localparam int SLOT_W = $clog2(SLOTS);

  logic             active, mode_rsp;
  logic [IDX_W-1:0] idx, sidx;
  logic [15:0]      acc;
  logic [31:0]      w;

  assign sidx = idx - IDX_W'(2);

  always_comb begin
    w = cell_buf[idx];
    if (mode_rsp) begin
      if (idx == '0)
        w = {cell_buf[0][31:24], 1'b1, cell_buf[0][22:8], status};
      else if (idx == IDX_W'(CELL_LEN - 1))
        w = {16'h0000, ~acc};
      else if (idx >= IDX_W'(2) && idx < IDX_W'(2 + SLOTS) && echo_vld[sidx[SLOT_W-1:0]])
        w = echo_slot[sidx[SLOT_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      mode_rsp  <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      done      <= 1'b0;
      if (!active && (start_pass || start_rsp)) begin
        active   <= 1'b1;
        mode_rsp <= start_rsp;
        idx      <= '0;
        acc      <= '0;
      end else if (active) begin
        out_valid <= 1'b1;
        out_sop   <= (idx == '0);
        out_data  <= w;
        acc       <= oc_word(acc, w);
        if (idx == IDX_W'(CELL_LEN - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R1: a started output cell continues on the next cycle
  a_r1_cell_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |=> (out_valid && !out_sop));
endmodule

// File: rtl/cellmem_proc.sv
module cellmem_proc
  import ccp_pkg::*;
#(
  parameter logic [7:0] MODULE_ID = 8'h2A,
  parameter int CELL_LEN = 20,
  parameter int SLOTS    = 16,
  parameter int ADDR_W   = 16,
  parameter int LIM32    = 8,
  parameter int LIM36    = 6,
  parameter int LIM64    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic [31:0]       out_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  logic [31:0]      cell_buf [CELL_LEN];
  logic [31:0]      slot_in  [SLOTS];
  logic [31:0]      echo_slot [SLOTS];
  logic [SLOTS-1:0] echo_vld;
  logic             rx_done, rx_ok, seq_err, seq_done, tx_done;
  logic             addressed, start_pass, start_seq, drop, release_c;
  hdr_t             hdr0;

  assign hdr0       = hdr_t'(cell_buf[0]);
  assign addressed  = (hdr0.mod_id == MODULE_ID) && !hdr0.rsp;
  assign start_pass = rx_done && !addressed;
  assign start_seq  = rx_done && addressed && rx_ok;
  assign drop       = rx_done && addressed && !rx_ok;
  assign release_c  = drop || tx_done;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_in[g] = cell_buf[2 + g];
  end

  ccp_rx #(.CELL_LEN(CELL_LEN)) u_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .release_i(release_c), .in_ready(in_ready), .cell_buf(cell_buf),
    .cell_done(rx_done), .cell_ok(rx_ok));

  ccp_seq #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .LIM32(LIM32), .LIM36(LIM36), .LIM64(LIM64)) u_seq (
    .clk(clk), .rst(rst), .start(start_seq), .hdr_i(hdr0),
    .base_i(cell_buf[1][ADDR_W-1:0]), .slot_in(slot_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .echo_slot(echo_slot), .echo_vld(echo_vld), .err(seq_err), .done(seq_done));

  ccp_tx #(.CELL_LEN(CELL_LEN), .SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst(rst), .start_pass(start_pass), .start_rsp(seq_done),
    .cell_buf(cell_buf), .echo_slot(echo_slot), .echo_vld(echo_vld),
    .status({7'd0, seq_err}), .out_valid(out_valid), .out_sop(out_sop),
    .out_data(out_data), .done(tx_done));

  // R10: memory traffic and response words never overlap
  a_r10_no_out_during_access: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !out_valid);
  // R2: a corrupted request is dropped quietly and input reopens
  a_r2_drop_silent: assert property (@(posedge clk) disable iff (rst)
    drop |=> (in_ready && !out_valid && !mem_req));
  // R3: a passed-through cell touches no memory
  a_r3_pass_no_access: assert property (@(posedge clk) disable iff (rst)
    start_pass |=> !mem_req);
endmodule

// File: tb/cellmem_proc_tb.sv
module cellmem_proc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 20;
  localparam logic [7:0] MY_ID = 8'h2A;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sop = 0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, mem_req, mem_we, mem_bank;
  logic [31:0] out_data;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  logic [63:0] mem0 [256];
  logic [63:0] mem1 [256];
  logic        pl_en = 0;
  logic [7:0]  pl_addr = '0;
  logic [63:0] pl_data = '0;
  logic        log_clr = 0;
  int          log_n;
  logic [15:0] log_addr [64];
  logic        log_we [64];
  logic        log_bank [64];
  int          overlap;

  logic [31:0] tx_cell [LEN];
  logic [31:0] rx_cell [LEN];
  logic [31:0] first_rsp [LEN];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellmem_proc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  // memory model: one-cycle read latency, access log
  always @(posedge clk) begin
    if (pl_en) mem1[pl_addr] <= pl_data;
    if (log_clr) log_n <= 0;
    if (out_valid && mem_req) overlap <= overlap + 1;
    if (mem_req) begin
      if (mem_we) begin
        if (mem_bank) mem1[mem_addr[7:0]] <= mem_wdata;
        else          mem0[mem_addr[7:0]] <= mem_wdata;
      end else begin
        mem_rdata <= mem_bank ? mem1[mem_addr[7:0]] : mem0[mem_addr[7:0]];
      end
      if (!log_clr && log_n < 64) begin
        log_addr[log_n] <= mem_addr;
        log_we[log_n]   <= mem_we;
        log_bank[log_n] <= mem_bank;
        log_n <= log_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic [7:0] id, input logic rsp, input logic [1:0] wid,
                                         input logic wr, input logic bank, input logic [3:0] cnt);
    return {id, rsp, wid, wr, bank, cnt, 7'h0, 8'h00};
  endfunction

  function automatic logic [15:0] fold(input bit use_rx, input int n);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w = use_rx ? rx_cell[i] : tx_cell[i];
      s = s + w[15:0] + w[31:16];
    end
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  task automatic new_req(input logic [7:0] id, input logic [1:0] wid, input logic wr,
                         input logic bank, input logic [3:0] cnt, input logic [31:0] addr);
    for (int i = 0; i < LEN; i++) tx_cell[i] = '0;
    tx_cell[0] = mk_hdr(id, 1'b0, wid, wr, bank, cnt);
    tx_cell[1] = addr;
  endtask

  task automatic seal();
    tx_cell[LEN-1] = {16'h0, ~fold(1'b0, LEN-1)};
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1; @(negedge clk); log_clr = 0;
  endtask

  task automatic send_cell();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < LEN; i++) begin
      in_valid = 1; in_sop = (i == 0); in_data = tx_cell[i];
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0;
  endtask

  task automatic recv_cell(output bit got);
    got = 0;
    for (int w = 0; w < 300 && !got; w++) begin
      if (out_valid && out_sop) got = 1;
      else @(negedge clk);
    end
    if (got) begin
      rx_cell[0] = out_data;
      for (int i = 1; i < LEN; i++) begin
        @(negedge clk);
        rx_cell[i] = out_valid ? out_data : 32'hDEAD_BEEF;
      end
    end
  endtask

  function automatic logic [31:0] rsp_hdr(input logic [7:0] st);
    return (tx_cell[0] | 32'h0080_0000) & 32'hFFFF_FF00 | {24'h0, st};
  endfunction

  task automatic chk_rsp_frame(input string tag, input logic [7:0] st);
    chk(rx_cell[0] == rsp_hdr(st), "R8", {tag, " header"}, rx_cell[0], rsp_hdr(st));
    chk(rx_cell[1] == tx_cell[1], "R8", {tag, " address echo"}, rx_cell[1], tx_cell[1]);
    chk(rx_cell[LEN-1] == {16'h0, ~fold(1'b1, LEN-1)}, "R8", {tag, " checksum"},
        rx_cell[LEN-1], {16'h0, ~fold(1'b1, LEN-1)});
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(mem_req == 1'b0, "R4", "mem_req after reset", mem_req, 0);
  endtask

  task automatic t_write32();
    bit got;
    clear_log();
    new_req(MY_ID, 2'd0, 1'b1, 1'b0, 4'd3, 32'h0000_0010);
    for (int i = 0; i < 3; i++) tx_cell[2+i] = 32'hA000_0001 + i;
    seal();
    send_cell();
    chk(in_ready == 1'b0, "R12", "in_ready low while cell held", in_ready, 0);
    recv_cell(got);
    chk(got, "R1", "write32 response present", got, 1);
    chk_rsp_frame("write32", 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk(rx_cell[2+i] == tx_cell[2+i], "R9", "write32 echo", rx_cell[2+i], tx_cell[2+i]);
      chk(mem0[8'h10+i] == {32'h0, tx_cell[2+i]}, "R4", "write32 stored", mem0[8'h10+i], {32'h0, tx_cell[2+i]});
    end
    chk(log_n == 3, "R4", "write32 access count", log_n, 3);
    for (int i = 0; i < 3; i++)
      chk(log_addr[i] == 16'h10 + i && log_we[i] && !log_bank[i], "R4", "write32 order/bank",
          {log_bank[i], log_we[i], log_addr[i]}, {1'b0, 1'b1, 16'h10 + 16'(i)});
  endtask

  task automatic t_read32();
    bit got;
    clear_log();
    new_req(MY_ID, 2'd0, 1'b0, 1'b0, 4'd3, 32'h0000_0010);
    seal();
    send_cell();
    recv_cell(got);
    chk(got, "R6", "read32 response present", got, 1);
    chk_rsp_frame("read32", 8'h00);
    for (int i = 0; i < 3; i++)
      chk(rx_cell[2+i] == 32'hA000_0001 + i, "R6", "read32 data", rx_cell[2+i], 32'hA000_0001 + i);
    chk(rx_cell[5] == 32'h0, "R8", "read32 unused slot echo", rx_cell[5], 0);
    chk(log_n == 3 && !log_we[0], "R4", "read32 accesses", log_n, 3);
  endtask

  task automatic t_write36();
    bit got;
    clear_log();
    new_req(MY_ID, 2'd1, 1'b1, 1'b1, 4'd6, 32'h0000_0040);
    for (int i = 0; i < 6; i++) begin
      tx_cell[2+2*i] = 32'hC0DE_0000 + i;
      tx_cell[3+2*i] = 32'hFFFF_FFF0 | i;
    end
    seal();
    send_cell();
    recv_cell(got);
    chk(got, "R7", "write36 at limit accepted", got, 1);
    chk_rsp_frame("write36", 8'h00);
    for (int i = 0; i < 6; i++) begin
      chk(mem1[8'h40+i] == {28'h0, 4'(i), 32'hC0DE_0000 + i}, "R5", "write36 stored",
          mem1[8'h40+i], {28'h0, 4'(i), 32'hC0DE_0000 + i});
      chk(rx_cell[3+2*i] == 32'(i), "R9", "write36 upper echo masked", rx_cell[3+2*i], i);
    end
  endtask

  task automatic t_read64();
    bit got;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pl_en = 1; pl_addr = 8'h80 + 8'(i); pl_data = {32'h1111_0000 + i, 32'h2222_0000 + i};
    end
    @(negedge clk); pl_en = 0;
    clear_log();
    new_req(MY_ID, 2'd2, 1'b0, 1'b1, 4'd4, 32'h0000_0080);
    tx_cell[12] = 32'h5A5A_5A5A;
    seal();
    send_cell();
    recv_cell(got);
    chk(got, "R6", "read64 response present", got, 1);
    chk_rsp_frame("read64", 8'h00);
    for (int i = 0; i < 4; i++) begin
      chk(rx_cell[2+2*i] == 32'h2222_0000 + i, "R5", "read64 low word", rx_cell[2+2*i], 32'h2222_0000 + i);
      chk(rx_cell[3+2*i] == 32'h1111_0000 + i, "R5", "read64 high word", rx_cell[3+2*i], 32'h1111_0000 + i);
    end
    chk(rx_cell[12] == 32'h5A5A_5A5A, "R8", "read64 spare data word echo", rx_cell[12], 32'h5A5A_5A5A);
    chk(log_n == 4 && log_bank[0], "R4", "read64 accesses on bank 1", log_n, 4);
  endtask

  task automatic bad_one(input logic [1:0] wid, input logic [3:0] cnt, input string tag);
    bit got;
    clear_log();
    new_req(MY_ID, wid, 1'b1, 1'b0, cnt, 32'h0000_0030);
    for (int i = 0; i < 16; i++) tx_cell[2+i] = 32'hBAD0_0000 + i;
    seal();
    send_cell();
    recv_cell(got);
    chk(got, "R7", {tag, " response present"}, got, 1);
    chk_rsp_frame(tag, 8'h01);
    chk(rx_cell[2] == tx_cell[2] && rx_cell[17] == tx_cell[17], "R7", {tag, " data unchanged"},
        rx_cell[17], tx_cell[17]);
    chk(log_n == 0, "R7", {tag, " no access"}, log_n, 0);
  endtask

  task automatic t_bad_header();
    bad_one(2'd0, 4'd9, "count 9 @32");
    bad_one(2'd2, 4'd5, "count 5 @64");
    bad_one(2'd1, 4'd7, "count 7 @36");
    bad_one(2'd3, 4'd1, "width 3");
    bad_one(2'd0, 4'd0, "count 0");
  endtask

  task automatic t_bad_cksum();
    bit got;
    clear_log();
    new_req(MY_ID, 2'd0, 1'b1, 1'b0, 4'd1, 32'h0000_0010);
    tx_cell[2] = 32'h0BAD_0BAD;
    seal();
    tx_cell[3] = tx_cell[3] ^ 32'h0000_0100;
    send_cell();
    recv_cell(got);
    chk(!got, "R2", "corrupted cell gives no output", got, 0);
    chk(log_n == 0, "R2", "corrupted cell no access", log_n, 0);
    chk(mem0[8'h10] == 64'hA000_0001, "R2", "memory untouched", mem0[8'h10], 64'hA000_0001);
    chk(in_ready, "R2", "input reopened after drop", in_ready, 1);
    new_req(MY_ID, 2'd0, 1'b0, 1'b0, 4'd1, 32'h0000_0011);
    seal();
    send_cell();
    recv_cell(got);
    chk(got && rx_cell[2] == 32'hA000_0002, "R2", "next good cell served", rx_cell[2], 32'hA000_0002);
  endtask

  task automatic pass_one(input logic [31:0] hdr, input bit corrupt, input string tag);
    bit got;
    clear_log();
    for (int i = 0; i < LEN; i++) tx_cell[i] = 32'h1234_0000 + 32'(i * 7);
    tx_cell[0] = hdr;
    seal();
    if (corrupt) tx_cell[5] = ~tx_cell[5];
    send_cell();
    recv_cell(got);
    chk(got, "R3", {tag, " emitted"}, got, 1);
    for (int i = 0; i < LEN; i++)
      if (rx_cell[i] != tx_cell[i])
        chk(0, "R3", {tag, " word differs"}, rx_cell[i], tx_cell[i]);
    chk(rx_cell[LEN-1] == tx_cell[LEN-1], "R3", {tag, " checksum word kept"}, rx_cell[LEN-1], tx_cell[LEN-1]);
    chk(log_n == 0, "R3", {tag, " no access"}, log_n, 0);
  endtask

  task automatic t_passthru();
    pass_one(mk_hdr(8'h11, 1'b0, 2'd0, 1'b1, 1'b0, 4'd2), 1'b0, "other id");
    pass_one(mk_hdr(MY_ID, 1'b1, 2'd0, 1'b1, 1'b0, 4'd2), 1'b0, "response flag");
    pass_one(mk_hdr(8'h33, 1'b0, 2'd0, 1'b1, 1'b0, 4'd2), 1'b1, "other id bad sum");
  endtask

  task automatic t_repeat();
    bit got;
    new_req(MY_ID, 2'd0, 1'b1, 1'b0, 4'd8, 32'h0000_00F0);
    for (int i = 0; i < 8; i++) tx_cell[2+i] = 32'h7700_0000 + 32'(i * 3);
    seal();
    clear_log();
    send_cell();
    recv_cell(got);
    for (int i = 0; i < LEN; i++) first_rsp[i] = rx_cell[i];
    chk(got && log_n == 8, "R7", "count 8 at 32-bit limit", log_n, 8);
    clear_log();
    send_cell();
    recv_cell(got);
    chk(got && log_n == 8, "R11", "repeat performs same accesses", log_n, 8);
    for (int i = 0; i < LEN; i++)
      if (rx_cell[i] != first_rsp[i]) chk(0, "R11", "repeat response differs", rx_cell[i], first_rsp[i]);
    chk(rx_cell[LEN-1] == first_rsp[LEN-1], "R11", "repeat checksum same", rx_cell[LEN-1], first_rsp[LEN-1]);
    chk(mem0[8'hF7] == {32'h0, 32'h7700_0015}, "R11", "repeat memory value", mem0[8'hF7], {32'h0, 32'h7700_0015});
  endtask

  initial begin
    overlap = 0;
    log_n = 0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) begin mem0[i] = '0; mem1[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write32();
    t_read32();
    t_write36();
    t_read64();
    t_bad_header();
    t_bad_cksum();
    t_passthru();
    t_repeat();
    chk(overlap == 0, "R10", "output during memory access", overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule